// File: doc/BRIEF.md
# ATA Cycle Timing Byte Encoder

This block converts a requested bus cycle, given as a total cycle time and an active-pulse time in nanoseconds, into the 8-bit read/write timing byte of a parallel ATA host controller. Both times are turned into bus clocks with the clock period supplied alongside them. Any recovery time longer than the field can hold is moved into the active phase. Both counts are then clamped and packed into two 4-bit fields, each with its own non-linear code.

A request is accepted on a one-cycle `start` strobe while the block is idle. The two ceiling divisions share a single sequential restoring divider, which produces one quotient bit per clock. When the byte and the counts behind it are valid, `done` pulses for one cycle. The outputs then hold their values until the next accepted request. A period input of zero selects the default 33 MHz bus clock, which is taken as 30 ns.

Top module: `ata_cyc_enc`

## Requirements
- R1: The cycle count is ceil(cycle_ns / P) and the raw active count is ceil(active_ns / P), each computed as (t + P - 1) / P in integer arithmetic, where P is the effective period. `cyc_cnt` reports the cycle count.
- R2: When `period_ns` is 0, the effective period P is 30 ns. Otherwise P is `period_ns`.
- R3: The recovery count is the cycle count minus the raw active count. It saturates at 0 when the raw active count is larger.
- R4: When that recovery count exceeds 16, the excess over 16 is added to the active count and the recovery count becomes 16.
- R5: After R4 is applied, the active count is clamped to at most 16. `act_cnt` and `rec_cnt` report the final counts, each in the range 0..16.
- R6: `timing_byte[7:4]` holds the low four bits of the final active count, so 16 is written as 0.
- R7: `timing_byte[3:0]` holds the recovery code. Counts 0 and 1 give 15, a count n from 2 to 15 gives n-1, and 16 gives 0.
- R8: `done` is high for exactly one cycle per accepted request. All outputs hold their values from that cycle until the next request completes.
- R9: A `start` pulse that arrives while a request is in progress is ignored, and the result is that of the request already running.
- R10: After reset, `done`, `timing_byte`, `cyc_cnt`, `act_cnt` and `rec_cnt` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, accepted only when idle |
| cycle_ns | input | TIME_W | Requested total cycle time in ns |
| active_ns | input | TIME_W | Requested active-pulse time in ns |
| period_ns | input | PER_W | Bus clock period in ns; 0 selects 30 ns |
| timing_byte | output | 8 | Encoded active nibble (7:4) and recovery nibble (3:0) |
| cyc_cnt | output | TIME_W+1 | Cycle count in clocks |
| act_cnt | output | 5 | Final active count, 0..16 |
| rec_cnt | output | 5 | Final recovery count, 0..16 |
| done | output | 1 | One-cycle pulse when the outputs are valid |

## Verification
The bench runs several groups of cases:
- The three fixed multiword DMA timings.
- Times that are exact multiples of the period and times one nanosecond past a multiple. A floor division, instead of a ceiling, would give a byte one clock short on the second kind.
- Long cycles, where a design that fails to move excess recovery into the active phase would show a wrong nibble. A design that fails to clamp the active count at 16 would also show a wrong nibble there.
- An active time longer than the cycle time, where a wrapping subtraction would produce a large recovery count instead of 0.
- Exact counts of 15 and 16, a zero period and a zero time, which expose off-by-one mistakes in the two nibble codes and in the default period.
- A second strobe sent during a busy request, which would corrupt the result if it were not ignored.

// File: rtl/ata_cyc_pkg.sv
package ata_cyc_pkg;
  localparam int CLK_MAX       = 16;
  localparam int NIB_W         = 4;
  localparam int FLD_W         = 5;
  localparam int DEF_PERIOD_NS = 1000 / 33;

  typedef enum logic [1:0] {ST_IDLE, ST_CYC, ST_ACT, ST_FIN} enc_state_e;

  // recovery field code: 0,1 -> 15; 2..15 -> n-1; 16 -> 0
  function automatic logic [NIB_W-1:0] rec_code(input logic [FLD_W-1:0] n);
    logic [FLD_W-1:0] m;
    m = n - FLD_W'(1);
    if (n < FLD_W'(2))             return NIB_W'(15);
    else if (n >= FLD_W'(CLK_MAX)) return NIB_W'(0);
    else                           return m[NIB_W-1:0];
  endfunction

  // active field code: low bits, so 16 wraps to 0
  function automatic logic [NIB_W-1:0] act_code(input logic [FLD_W-1:0] n);
    return n[NIB_W-1:0];
  endfunction
endpackage

// File: rtl/ata_ceil_div.sv
module ata_ceil_div #(
  parameter int N = 11,
  parameter int D = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] num,
  input  logic [D-1:0] den,
  output logic [N-1:0] quot,
  output logic         fin
);
  localparam int CW = $clog2(N + 1);

  logic [N-1:0]  sh;
  logic [D-1:0]  rem;
  logic [D-1:0]  den_q;
  logic [CW-1:0] left;
  logic          run;
  logic [D:0]    rem_sh;
  logic [D:0]    rem_nx;
  logic          step_ge;

  always_comb begin
    rem_sh  = {rem, sh[N-1]};
    step_ge = (rem_sh >= {1'b0, den_q});
    rem_nx  = step_ge ? (rem_sh - {1'b0, den_q}) : rem_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      rem   <= '0;
      den_q <= '0;
      left  <= '0;
      run   <= 1'b0;
      fin   <= 1'b0;
    end else if (go) begin
      sh    <= num;
      rem   <= '0;
      den_q <= den;
      left  <= CW'(N);
      run   <= 1'b1;
      fin   <= 1'b0;
    end else if (run) begin
      sh   <= {sh[N-2:0], step_ge};
      rem  <= rem_nx[D-1:0];
      left <= left - CW'(1);
      if (left == CW'(1)) begin
        run <= 1'b0;
        fin <= 1'b1;
      end
    end else begin
      fin <= 1'b0;
    end
  end

  assign quot = sh;
endmodule

// File: rtl/ata_count_fix.sv
module ata_count_fix
  import ata_cyc_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] act_raw,
  output logic [FLD_W-1:0] act_fin,
  output logic [FLD_W-1:0] rec_fin
);
  logic [CNT_W:0] rec_raw;
  logic [CNT_W:0] act_sum;

  always_comb begin
    rec_raw = (cyc > act_raw) ? ({1'b0, cyc} - {1'b0, act_raw}) : '0;
    if (rec_raw > (CNT_W+1)'(CLK_MAX)) begin
      act_sum = {1'b0, act_raw} + rec_raw - (CNT_W+1)'(CLK_MAX);
      rec_fin = FLD_W'(CLK_MAX);
    end else begin
      act_sum = {1'b0, act_raw};
      rec_fin = rec_raw[FLD_W-1:0];
    end
    act_fin = (act_sum > (CNT_W+1)'(CLK_MAX)) ? FLD_W'(CLK_MAX) : act_sum[FLD_W-1:0];
  end
endmodule

// File: rtl/ata_nibble_enc.sv
module ata_nibble_enc
  import ata_cyc_pkg::*;
(
  input  logic [FLD_W-1:0] act_fin,
  input  logic [FLD_W-1:0] rec_fin,
  output logic [7:0]       byte_out
);
  assign byte_out = {act_code(act_fin), rec_code(rec_fin)};
endmodule

// File: rtl/ata_cyc_enc.sv
module ata_cyc_enc
  import ata_cyc_pkg::*;
#(
  parameter int TIME_W = 10,
  parameter int PER_W  = 6,
  localparam int CNT_W = TIME_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TIME_W-1:0] cycle_ns,
  input  logic [TIME_W-1:0] active_ns,
  input  logic [PER_W-1:0]  period_ns,
  output logic [7:0]        timing_byte,
  output logic [CNT_W-1:0]  cyc_cnt,
  output logic [FLD_W-1:0]  act_cnt,
  output logic [FLD_W-1:0]  rec_cnt,
  output logic              done
);
  enc_state_e        state;
  logic [TIME_W-1:0] act_q;
  logic [PER_W-1:0]  per_q;
  logic [CNT_W-1:0]  cyc_q;
  logic [CNT_W-1:0]  act_raw_q;
  logic              div_go;
  logic [CNT_W-1:0]  div_num;
  logic [PER_W-1:0]  div_den;
  logic [CNT_W-1:0]  div_quot;
  logic              div_fin;
  logic [FLD_W-1:0]  act_fix;
  logic [FLD_W-1:0]  rec_fix;
  logic [7:0]        byte_nx;
  logic              busy;
  logic              accept;

  function automatic logic [PER_W-1:0] eff_period(input logic [PER_W-1:0] p);
    return (p == '0) ? PER_W'(DEF_PERIOD_NS) : p;
  endfunction

  function automatic logic [CNT_W-1:0] ceil_num(input logic [TIME_W-1:0] t,
                                                input logic [PER_W-1:0]  p);
    return {1'b0, t} + CNT_W'(p) - CNT_W'(1);
  endfunction

  assign busy   = (state != ST_IDLE);
  assign accept = (state == ST_IDLE) && start;
  assign div_go = accept || ((state == ST_CYC) && div_fin);

  always_comb begin
    if (state == ST_IDLE) begin
      div_den = eff_period(period_ns);
      div_num = ceil_num(cycle_ns, div_den);
    end else begin
      div_den = per_q;
      div_num = ceil_num(act_q, per_q);
    end
  end

  ata_ceil_div #(.N(CNT_W), .D(PER_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (div_den),
    .quot  (div_quot),
    .fin   (div_fin)
  );

  ata_count_fix #(.CNT_W(CNT_W)) u_fix (
    .cyc     (cyc_q),
    .act_raw (act_raw_q),
    .act_fin (act_fix),
    .rec_fin (rec_fix)
  );

  ata_nibble_enc u_enc (
    .act_fin  (act_fix),
    .rec_fin  (rec_fix),
    .byte_out (byte_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      act_q       <= '0;
      per_q       <= '0;
      cyc_q       <= '0;
      act_raw_q   <= '0;
      timing_byte <= '0;
      cyc_cnt     <= '0;
      act_cnt     <= '0;
      rec_cnt     <= '0;
      done        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          act_q <= active_ns;
          per_q <= eff_period(period_ns);
          state <= ST_CYC;
        end
        ST_CYC: if (div_fin) begin
          cyc_q <= div_quot;
          state <= ST_ACT;
        end
        ST_ACT: if (div_fin) begin
          act_raw_q <= div_quot;
          state     <= ST_FIN;
        end
        default: begin
          timing_byte <= byte_nx;
          cyc_cnt     <= cyc_q;
          act_cnt     <= act_fix;
          rec_cnt     <= rec_fix;
          done        <= 1'b1;
          state       <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ata_cyc_enc_chk.sv
module ata_cyc_enc_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [4:0]       act_cnt,
  input logic [4:0]       rec_cnt,
  input logic [7:0]       timing_byte
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(timing_byte));

  p_rec_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rec_cnt <= 5'd16));

  p_act_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (act_cnt <= 5'd16));

  p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rec_cnt != 5'd0 && rec_cnt != 5'd16 && act_cnt != 5'd16)
      |-> (CNT_W'(act_cnt) + CNT_W'(rec_cnt) == cyc_cnt));

  p_nibble_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (timing_byte[7:4] == act_cnt[3:0]));
endmodule

bind ata_cyc_enc ata_cyc_enc_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ata_cyc_enc_tb_top.sv
`timescale 1ns/1ps
module ata_cyc_enc_tb_top;
  typedef struct packed {
    logic [9:0] c;
    logic [9:0] a;
    logic [5:0] p;
    logic [7:0] b;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{10'd120,  10'd70,   6'd30, 8'h3F},
    '{10'd150,  10'd80,   6'd30, 8'h31},
    '{10'd480,  10'd215,  6'd30, 8'h87},
    '{10'd120,  10'd70,   6'd0,  8'h3F},
    '{10'd1000, 10'd100,  6'd30, 8'h00},
    '{10'd600,  10'd60,   6'd30, 8'h40},
    '{10'd60,   10'd200,  6'd30, 8'h7F},
    '{10'd500,  10'd480,  6'd30, 8'h0F},
    '{10'd600,  10'd150,  6'd30, 8'h5E},
    '{10'd100,  10'd40,   6'd10, 8'h45},
    '{10'd121,  10'd70,   6'd30, 8'h31},
    '{10'd0,    10'd0,    6'd30, 8'h0F},
    '{10'd90,   10'd30,   6'd30, 8'h11},
    '{10'd1023, 10'd1023, 6'd63, 8'h0F},
    '{10'd1023, 10'd5,    6'd1,  8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [9:0]  cycle_ns = '0;
  logic [9:0]  active_ns = '0;
  logic [5:0]  period_ns = '0;
  logic [7:0]  timing_byte;
  logic [10:0] cyc_cnt;
  logic [4:0]  act_cnt;
  logic [4:0]  rec_cnt;
  logic        done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ata_cyc_enc dut_i (.*);

  task automatic check(input string what, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, got, exp);
    end
  endtask

  // independent model of the requirements
  task automatic model(input int c, input int a, input int p,
                       output int ec, output int ea, output int er);
    int pp, ca, r;
    pp = (p == 0) ? 30 : p;
    ec = (c + pp - 1) / pp;
    ca = (a + pp - 1) / pp;
    r  = (ec > ca) ? ec - ca : 0;
    if (r > 16) begin ca = ca + (r - 16); r = 16; end
    ea = (ca > 16) ? 16 : ca;
    er = r;
  endtask

  task automatic pulse_start(input int c, input int a, input int p);
    @(negedge clk);
    cycle_ns = 10'(c); active_ns = 10'(a); period_ns = 6'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int k = 0; k < 200; k++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run_case(input int c, input int a, input int p, input int eb);
    int ec, ea, er;
    bit seen;
    model(c, a, p, ec, ea, er);
    pulse_start(c, a, p);
    wait_done(seen);
    check("R8 done seen", int'(seen), 1);
    check("R1 cycle count", int'(cyc_cnt), ec);
    check("R3 R4 R5 active count", int'(act_cnt), ea);
    check("R3 R4 recovery count", int'(rec_cnt), er);
    check("R6 R7 timing byte", int'(timing_byte), eb);
    @(negedge clk);
    check("R8 done one cycle", int'(done), 0);
    check("R8 byte held", int'(timing_byte), eb);
  endtask

  initial begin
    int ec, ea, er;
    bit seen;
    repeat (3) @(negedge clk);
    // R10 reset values
    check("R10 done reset", int'(done), 0);
    check("R10 byte reset", int'(timing_byte), 0);
    check("R10 cyc_cnt reset", int'(cyc_cnt), 0);
    check("R10 act_cnt reset", int'(act_cnt), 0);
    check("R10 rec_cnt reset", int'(rec_cnt), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_case(int'(VECS[i].c), int'(VECS[i].a), int'(VECS[i].p), int'(VECS[i].b));

    // R2: zero period uses 30 ns, here 60/30 = 2 clocks exactly
    run_case(60, 30, 0, 8'h1F);

    // R9: second strobe while busy is ignored
    pulse_start(480, 215, 30);
    repeat (3) @(negedge clk);
    cycle_ns = 10'd120; active_ns = 10'd70; period_ns = 6'd10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(seen);
    model(480, 215, 30, ec, ea, er);
    check("R9 done seen", int'(seen), 1);
    check("R9 byte of first request", int'(timing_byte), 8'h87);
    check("R9 cycle count of first request", int'(cyc_cnt), ec);
    @(negedge clk);
    repeat (40) begin
      check("R9 no second done", int'(done), 0);
      @(negedge clk);
    end
    check("R8 R9 byte still held", int'(timing_byte), 8'h87);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule